// File: doc/BRIEF.md
# Board Test Mode XNOR-Chain Controller

This block places a device into a board-level connectivity test and builds a continuity chain through its pads. When the active-low system reset pin is released, it samples two strap inputs: the interface frame strobe, which is active low, and interface data bit 0. It then records in a flag whether the device should run in normal or in test mode. The flag keeps its value until the next release of the system reset.

In normal mode each functional pad passes straight through. The core's output and output enable go to the pad, and the pad value returns to the core. In test mode the block cuts the core off every pad. It turns every chained pad into an input and returns zero to the core. One dedicated pad, a general-purpose pin in normal use, is taken over as an output. That pad drives a registered serial XNOR reduction of all chained pad inputs. Board test equipment toggles pads one at a time and watches the chain output for a matching toggle. The system reset pin is not a pad of the chain. A free-running clock times the block, and a synchronous active-high block reset sets it to normal mode.

Top module: `btm_xnor_ctrl`

## Requirements
- R1: When the synchronized system reset pin changes from 0 to 1, the block enters test mode if the synchronized frame strobe and data bit 0 are both 0. The mode flag changes SYNC_STAGES+1 clock edges after the pin rises.
- R2: When the synchronized system reset pin changes from 0 to 1 while the frame strobe or data bit 0 reads 1, the block leaves test mode, or stays in normal mode.
- R3: Strap changes have no effect on the mode at any time other than a release edge of the system reset pin. This holds while the reset pin stays high and while it stays low.
- R4: In test mode every chained pad has pad_oe = 0 and pad_out = 0, and core_in reads all zeros whatever the pad inputs are.
- R5: In test mode the chain output pad has gp_pad_oe = 1 and drives the chain result, and gp_core_in reads 0.
- R6: The chain result is stage[0] = pad_in[0] and stage[i] = XNOR(pad_in[i], stage[i-1]), taken one clock after pad_in. This equals the XOR of all inputs, inverted when N_PADS-1 is odd. Toggling any single chained input toggles the chain output one clock later.
- R7: In normal mode pad_out = core_out, pad_oe = core_oe and core_in = pad_in. The chain output pad likewise passes gp_core_out and gp_core_oe through and returns gp_pad_in.
- R8: The system reset pin does not feed the chain. While it is held low, the mode and the chain output stay unchanged for constant pad inputs.
- R9: A block reset (rst = 1) puts the block in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_n | input | 1 | System reset pin, active low; its release samples the straps |
| strap_frame_n | input | 1 | Frame strobe strap, active low |
| strap_dat0 | input | 1 | Data bit 0 strap |
| core_out | input | N_PADS | Functional output values from the core |
| core_oe | input | N_PADS | Functional output enables from the core |
| core_in | output | N_PADS | Pad values returned to the core |
| pad_out | output | N_PADS | Values driven to the chained pads |
| pad_oe | output | N_PADS | Output enables of the chained pads |
| pad_in | input | N_PADS | Values read from the chained pads |
| gp_core_out | input | 1 | Core output value for the shared chain-output pad |
| gp_core_oe | input | 1 | Core output enable for the shared chain-output pad |
| gp_core_in | output | 1 | Shared pad value returned to the core |
| gp_pad_out | output | 1 | Value driven on the chain output pad |
| gp_pad_oe | output | 1 | Output enable of the chain output pad |
| gp_pad_in | input | 1 | Value read from the chain output pad |

## Verification
A wrong mode flag shows at once at the pads, on the first sample after the release window of SYNC_STAGES+1 clocks. The output enables either follow the core or all drop to zero, and the chain pad's enable flips. A wrong link in the chain shows one clock after a single pad toggles: the chain output fails to toggle, or it settles to the wrong parity. A flag that reloads outside a release edge shows as a mode change after straps move while the reset pin is steady.

// File: rtl/btm_pkg.sv
package btm_pkg;
  // One synchronizer slot: the reset pin and the two strap pins
  typedef struct packed {
    logic rel_n;
    logic frame_n;
    logic dat0;
  } strap_t;

  localparam strap_t STRAP_IDLE = '{rel_n: 1'b0, frame_n: 1'b1, dat0: 1'b1};
endpackage

// File: rtl/btm_strap_latch.sv
module btm_strap_latch
  import btm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_rst_n,
  input  logic strap_frame_n,
  input  logic strap_dat0,
  output logic test_mode,
  output logic rel_pulse,
  output logic frame_s,
  output logic dat0_s
);
  localparam int LAST = SYNC_STAGES - 1;

  strap_t sync_q [SYNC_STAGES];
  logic   rel_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= STRAP_IDLE;
    end else begin
      sync_q[0] <= '{rel_n: sys_rst_n, frame_n: strap_frame_n, dat0: strap_dat0};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign rel_pulse = sync_q[LAST].rel_n & ~rel_prev_q;
  assign frame_s   = sync_q[LAST].frame_n;
  assign dat0_s    = sync_q[LAST].dat0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_prev_q <= 1'b0;
      test_mode  <= 1'b0;
    end else begin
      rel_prev_q <= sync_q[LAST].rel_n;
      if (rel_pulse) test_mode <= ~frame_s & ~dat0_s;
    end
  end
endmodule

// File: rtl/btm_xnor_chain.sv
module btm_xnor_chain #(
  parameter int N_PADS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PADS-1:0] din,
  output logic              chain_q
);
  logic [N_PADS-1:0] stage;

  assign stage[0] = din[0];
  for (genvar g = 1; g < N_PADS; g++) begin : g_link
    assign stage[g] = ~(din[g] ^ stage[g-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= 1'b0;
    else     chain_q <= stage[N_PADS-1];
  end
endmodule

// File: rtl/btm_pad_gate.sv
module btm_pad_gate (
  input  logic test_mode,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  output logic core_in,
  output logic pad_out,
  output logic pad_oe
);
  always_comb begin
    if (test_mode) begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
      core_in = 1'b0;
    end else begin
      pad_out = core_out;
      pad_oe  = core_oe;
      core_in = pad_in;
    end
  end
endmodule

// File: rtl/btm_xnor_ctrl.sv
module btm_xnor_ctrl #(
  parameter int N_PADS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_rst_n,
  input  logic              strap_frame_n,
  input  logic              strap_dat0,
  input  logic [N_PADS-1:0] core_out,
  input  logic [N_PADS-1:0] core_oe,
  output logic [N_PADS-1:0] core_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe,
  input  logic [N_PADS-1:0] pad_in,
  input  logic              gp_core_out,
  input  logic              gp_core_oe,
  output logic              gp_core_in,
  output logic              gp_pad_out,
  output logic              gp_pad_oe,
  input  logic              gp_pad_in
);
  logic test_mode;
  logic rel_pulse;
  logic frame_s;
  logic dat0_s;
  logic chain_q;

  btm_strap_latch #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
    .clk          (clk),
    .rst          (rst),
    .sys_rst_n    (sys_rst_n),
    .strap_frame_n(strap_frame_n),
    .strap_dat0   (strap_dat0),
    .test_mode    (test_mode),
    .rel_pulse    (rel_pulse),
    .frame_s      (frame_s),
    .dat0_s       (dat0_s)
  );

  btm_xnor_chain #(.N_PADS(N_PADS)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .din    (pad_in),
    .chain_q(chain_q)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    btm_pad_gate u_gate (
      .test_mode(test_mode),
      .core_out (core_out[p]),
      .core_oe  (core_oe[p]),
      .pad_in   (pad_in[p]),
      .core_in  (core_in[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p])
    );
  end

  // Shared pad: taken over as the chain result driver in test mode
  always_comb begin
    if (test_mode) begin
      gp_pad_out = chain_q;
      gp_pad_oe  = 1'b1;
      gp_core_in = 1'b0;
    end else begin
      gp_pad_out = gp_core_out;
      gp_pad_oe  = gp_core_oe;
      gp_core_in = gp_pad_in;
    end
  end
endmodule

// File: rtl/btm_xnor_ctrl_chk.sv
module btm_xnor_ctrl_chk #(
  parameter int N_PADS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              test_mode,
  input logic              rel_pulse,
  input logic              frame_s,
  input logic              dat0_s,
  input logic [N_PADS-1:0] pad_in,
  input logic [N_PADS-1:0] pad_oe,
  input logic [N_PADS-1:0] core_in,
  input logic [N_PADS-1:0] core_oe,
  input logic              gp_pad_oe,
  input logic              gp_pad_out
);
  localparam logic PAR = logic'((N_PADS - 1) % 2);

  p_enter_r1: assert property (@(posedge clk) disable iff (rst)
    (rel_pulse && !frame_s && !dat0_s) |=> test_mode);

  p_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (rel_pulse && (frame_s || dat0_s)) |=> !test_mode);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rel_pulse |=> $stable(test_mode));

  p_pads_in_r4: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> (pad_oe == '0 && core_in == '0));

  p_gp_drive_r5: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> gp_pad_oe);

  p_chain_r6: assert property (@(posedge clk) disable iff (rst)
    (test_mode && $past(test_mode)) |-> (gp_pad_out == ((^$past(pad_in)) ^ PAR)));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    !test_mode |-> (pad_oe == core_oe && core_in == pad_in));
endmodule

bind btm_xnor_ctrl btm_xnor_ctrl_chk #(.N_PADS(N_PADS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_mode (test_mode),
  .rel_pulse (rel_pulse),
  .frame_s   (frame_s),
  .dat0_s    (dat0_s),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .core_in   (core_in),
  .core_oe   (core_oe),
  .gp_pad_oe (gp_pad_oe),
  .gp_pad_out(gp_pad_out)
);

// File: tb/sim_btm_xnor_ctrl.sv
module sim_btm_xnor_ctrl;
  localparam int  N        = 8;
  localparam int  SS       = 2;
  localparam time CLK_HALF = 5ns;
  localparam logic PAR     = logic'((N - 1) % 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_rst_n = 1'b0;
  logic strap_frame_n = 1'b1;
  logic strap_dat0 = 1'b1;
  logic [N-1:0] core_out = '0;
  logic [N-1:0] core_oe = '1;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] core_in, pad_out, pad_oe;
  logic gp_core_out = 1'b0;
  logic gp_core_oe = 1'b0;
  logic gp_pad_in = 1'b0;
  logic gp_core_in, gp_pad_out, gp_pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  btm_xnor_ctrl #(.N_PADS(N), .SYNC_STAGES(SS)) u0 (.*);

  // {frame_n, dat0, expected test mode}
  localparam logic [2:0] VEC [4] = '{3'b001, 3'b010, 3'b100, 3'b110};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic release_with(input logic f, input logic d);
    @(negedge clk);
    sys_rst_n = 1'b0;
    strap_frame_n = f;
    strap_dat0 = d;
    repeat (4) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (SS + 4) @(negedge clk);
  endtask

  // mode seen at the ports with core_oe all ones and gp_core_oe low
  task automatic chk_mode(input string req, input logic exp);
    core_oe = '1;
    gp_core_oe = 1'b0;
    #1;
    chk(req, {pad_oe, gp_pad_oe}, exp ? {{N{1'b0}}, 1'b1} : {{N{1'b1}}, 1'b0});
  endtask

  function automatic logic chain_of(input logic [N-1:0] v);
    return (^v) ^ PAR;
  endfunction

  initial begin
    logic last;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_mode("R9 reset state normal", 1'b0);

    // R1 / R2: all four strap combinations
    for (int i = 0; i < 4; i++) begin
      release_with(VEC[i][2], VEC[i][1]);
      chk_mode(VEC[i][0] ? "R1 enter" : "R2 exit", VEC[i][0]);
    end

    // R7: pass-through in normal mode
    release_with(1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      core_out = 8'h3C ^ 8'(k * 8'h51);
      core_oe = 8'hA5 ^ 8'(k * 8'h1F);
      pad_in = 8'h96 ^ 8'(k * 8'h27);
      gp_core_out = k[0];
      gp_core_oe = ~k[0];
      gp_pad_in = ~k[0];
      #1;
      chk("R7 pad_out", pad_out, core_out);
      chk("R7 pad_oe", pad_oe, core_oe);
      chk("R7 core_in", core_in, pad_in);
      chk("R7 gp pass", {gp_pad_out, gp_pad_oe, gp_core_in}, {gp_core_out, gp_core_oe, gp_pad_in});
      @(negedge clk);
    end

    // R4 / R5: test mode isolation
    release_with(1'b0, 1'b0);
    pad_in = 8'hA5;
    core_out = '1;
    gp_core_out = 1'b0;
    gp_pad_in = 1'b1;
    chk_mode("R4 R5 tri-state in test", 1'b1);
    chk("R4 core_in zero", core_in, '0);
    chk("R4 pad_out zero", pad_out, '0);
    chk("R5 gp_core_in zero", gp_core_in, 1'b0);

    // R6: walk a single toggle through each chained input
    pad_in = '0;
    @(negedge clk);
    chk("R6 chain all zero", gp_pad_out, chain_of('0));
    for (int b = 0; b < N; b++) begin
      last = gp_pad_out;
      pad_in[b] = ~pad_in[b];
      @(negedge clk);
      chk("R6 chain toggle", {gp_pad_out, gp_pad_out ^ last}, {chain_of(pad_in), 1'b1});
    end
    pad_in = 8'h5A;
    @(negedge clk);
    chk("R6 chain pattern", gp_pad_out, chain_of(8'h5A));

    // R3: straps move while the reset pin stays high
    strap_frame_n = 1'b1;
    strap_dat0 = 1'b1;
    repeat (SS + 4) @(negedge clk);
    chk_mode("R3 hold while released", 1'b1);

    // R8: reset pin held low; mode and chain unchanged
    last = gp_pad_out;
    sys_rst_n = 1'b0;
    repeat (SS + 4) @(negedge clk);
    chk_mode("R3 hold while reset low", 1'b1);
    chk("R8 chain unaffected by reset pin", gp_pad_out, last);

    // R2: leave test mode with one strap high
    sys_rst_n = 1'b1;
    release_with(1'b0, 1'b1);
    chk_mode("R2 exit on dat0 high", 1'b0);

    // R9: block reset from test mode
    release_with(1'b0, 1'b0);
    chk_mode("R1 re-enter", 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sys_rst_n = 1'b0;
    #1;
    chk_mode("R9 block reset clears mode", 1'b0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule